// File: doc/BRIEF.md
# SPI Master with Start-Up Delay

This block is a single-channel serial master that shifts one word out on MOSI while it samples MISO, using clock mode 0 (SCLK idles low, data is sampled on the rising edge and changes on the falling edge). Software-style configuration inputs set the word length, choose between a 4-wire link with an active-low select and a 3-wire link without one, mark the port as slave, enable the channel, and pick a start-up delay code. A word is handed over through a holding register with a write strobe. The received word appears in an RX register together with a valid flag.

After the channel is enabled and the first word is written, the engine can wait a coded number of serial-clock periods before that word goes out. During the wait SCLK stays low and the select stays high. SCLK comes from the system clock through a fixed even divider, and the wait is counted in whole SCLK periods. The wait happens once for each enable. Later words follow with no gap until the channel is disabled and enabled again. When the slave bit is set, the master engine does nothing.

Top module: `spi_delay_master`

## Requirements
- R1: While reset is asserted and right after it is released, cs_n is 1, sclk is 0, mosi is 0, tx_busy is 0, rx_valid is 0 and rx_data is 0.
- R2: The delay code selects the wait before the first word after enable: 0 gives no wait, 1 gives 4, 2 gives 8, 3 gives 16 and 4 gives 32 SCLK periods, where one period is SYS_DIV system cycles. Codes 5, 6 and 7 give no wait. With a wait of D system cycles, the first SCLK rise is seen D+1+SYS_DIV/2 cycles after the clock edge that samples the write strobe.
- R3: During the wait sclk stays 0 and cs_n stays 1, even in 4-wire mode. In 4-wire mode cs_n goes low D+1 cycles after the write edge and stays low through the word. SCLK never pulses while cs_n is high.
- R4: The wait is applied only to the first word after the channel is enabled. A word written later, while the channel stays enabled, starts with D=0. Clearing and setting cfg_en arms the wait again.
- R5: A word written while cfg_en is 0 is held, and tx_busy stays 1. The word starts, with the wait applied, once cfg_en goes to 1. Counting from the edge that samples cfg_en=1, cs_n falls after D cycles.
- R6: While cfg_slave is 1 no word is sent: sclk stays 0 and cs_n stays 1, and a held word stays pending with tx_busy at 1. The held word is sent once cfg_slave returns to 0.
- R7: When cfg_three_pin is 1, cs_n is never driven low, but the word is still shifted on SCLK, MOSI and MISO.
- R8: The word length W is cfg_wlen, limited to the range 4 to 16. A value below 4 acts as 4 and a value above 16 acts as 16. The bits tx_data[W-1:0] go out MSB first, one per SCLK period, and exactly W rising edges occur. The W bits sampled on MISO land in rx_data[W-1:0], and the upper bits of rx_data are 0.
- R9: rx_valid goes to 1 on the rising SCLK edge that samples the last bit, which is D+1+(W-1)*SYS_DIV+SYS_DIV/2 cycles after the write edge. It stays at 1 until a write is accepted.
- R10: tx_busy is 1 from the write edge until D+1+W*SYS_DIV cycles later. A write made in any cycle in which tx_busy is 1, the final busy cycle included, is ignored and starts no transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Channel enable; a rising edge arms the start-up wait |
| cfg_slave | input | 1 | 1 = slave selected; the master engine stays idle |
| cfg_three_pin | input | 1 | 1 = 3-wire link, select never asserted |
| cfg_dly_code | input | 3 | Start-up delay code |
| cfg_wlen | input | 5 | Word length in bits (4 to 16, limited to that range) |
| tx_data | input | 16 | Word to send |
| tx_wr | input | 1 | Write strobe for the holding register |
| tx_busy | output | 1 | Holding register full or word in progress |
| rx_data | output | 16 | Last received word, right-aligned |
| rx_valid | output | 1 | Received word available |
| sclk | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Active-low select (4-wire master only) |

## Verification
Two events can land in the same cycle. One is the final busy cycle of a word, where the FSM returns to idle. The other is a new write strobe. The design ignores that write, so the strobe is placed on exactly the cycle before busy clears. The bench then checks that tx_busy is low afterwards, that cs_n stays high for many cycles, and that rx_data and rx_valid still hold the finished word. A second pairing is a disable or a slave selection arriving while a word is pending. The bench holds a word under each condition, then releases the condition and measures the start-up timing from the release edge.

// File: rtl/spi_dly_pkg.sv
package spi_dly_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_WAIT  = 2'd1,
      ST_SHIFT = 2'd2
   } eng_state_t;

   localparam int unsigned MAX_WAIT_PERIODS = 32;

   // Translate the start-up code into a number of SCLK periods.
   // Codes 5..7 carry no wait.
   function automatic logic [5:0] code_to_periods(input logic [2:0] code);
      case (code)
         3'd1:    return 6'd4;
         3'd2:    return 6'd8;
         3'd3:    return 6'd16;
         3'd4:    return 6'd32;
         default: return 6'd0;
      endcase
   endfunction

endpackage

// File: rtl/spi_phase_gen.sv
module spi_phase_gen #(
   parameter int DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic sclk_lvl,
   output logic sample_now,
   output logic period_end
);
   localparam int HALF = DIV / 2;
   localparam int PHW  = (DIV > 2) ? $clog2(DIV) : 1;

   generate
      if (DIV == 2) begin : g_toggle
         logic ph;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   ph <= 1'b0;
            else if (!run) ph <= 1'b0;
            else          ph <= ~ph;
         end
         assign sclk_lvl   = run & ph;
         assign sample_now = run & ~ph;
         assign period_end = run & ph;
      end else begin : g_count
         localparam logic [PHW-1:0] PH_LAST = PHW'(DIV - 1);
         localparam logic [PHW-1:0] PH_HALF = PHW'(HALF);
         localparam logic [PHW-1:0] PH_SMP  = PHW'(HALF - 1);
         logic [PHW-1:0] ph;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)             ph <= '0;
            else if (!run)          ph <= '0;
            else if (ph == PH_LAST) ph <= '0;
            else                    ph <= ph + 1'b1;
         end
         assign sclk_lvl   = run && (ph >= PH_HALF);
         assign sample_now = run && (ph == PH_SMP);
         assign period_end = run && (ph == PH_LAST);

         AST_PHASE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
            ph <= PH_LAST); // R8
      end
   endgenerate

endmodule

// File: rtl/spi_start_delay.sv
module spi_start_delay #(
   parameter int CW = 7
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic          clear,
   input  logic [CW-1:0] load_val,
   output logic          expired
);
   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         cnt <= '0;
      else if (clear)     cnt <= '0;
      else if (load)      cnt <= load_val;
      else if (cnt != '0) cnt <= cnt - 1'b1;
   end

   assign expired = (cnt == '0);

   AST_DLY_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == '0 && !load) |=> (cnt == '0)); // R2

endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core #(
   parameter int MAX_WL = 16,
   parameter int WLW    = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [WLW-1:0]    wl,
   input  logic [MAX_WL-1:0] tx_word,
   input  logic              sample_now,
   input  logic              period_end,
   input  logic              miso,
   output logic              mosi,
   output logic              last_bit,
   output logic [MAX_WL-1:0] rx_word
);
   logic [MAX_WL-1:0] sreg;
   logic [MAX_WL-1:0] rx_sh;
   logic [WLW-1:0]    bitcnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sreg   <= '0;
         rx_sh  <= '0;
         bitcnt <= '0;
      end else if (load) begin
         sreg   <= tx_word << (MAX_WL - int'(wl));
         rx_sh  <= '0;
         bitcnt <= wl - 1'b1;
      end else begin
         if (sample_now)
            rx_sh <= {rx_sh[MAX_WL-2:0], miso};
         if (period_end && bitcnt != '0) begin
            sreg   <= sreg << 1;
            bitcnt <= bitcnt - 1'b1;
         end
      end
   end

   assign mosi     = sreg[MAX_WL-1];
   assign last_bit = (bitcnt == '0);
   assign rx_word  = {rx_sh[MAX_WL-2:0], miso};

endmodule

// File: rtl/spi_delay_master.sv
module spi_delay_master
   import spi_dly_pkg::*;
#(
   parameter int SYS_DIV = 4,
   parameter int MAX_WL  = 16,
   parameter int MIN_WL  = 4,
   localparam int WLW    = $clog2(MAX_WL + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_en,
   input  logic              cfg_slave,
   input  logic              cfg_three_pin,
   input  logic [2:0]        cfg_dly_code,
   input  logic [WLW-1:0]    cfg_wlen,
   input  logic [MAX_WL-1:0] tx_data,
   input  logic              tx_wr,
   output logic              tx_busy,
   output logic [MAX_WL-1:0] rx_data,
   output logic              rx_valid,
   output logic              sclk,
   output logic              mosi,
   input  logic              miso,
   output logic              cs_n
);
   localparam int DCW = $clog2(MAX_WAIT_PERIODS * SYS_DIV);

   if (SYS_DIV < 2 || (SYS_DIV % 2) != 0) begin : g_div_chk
      $error("SYS_DIV must be even and at least 2");
   end
   if (MIN_WL < 2 || MAX_WL < MIN_WL) begin : g_wl_chk
      $error("word length range is inconsistent");
   end

   eng_state_t        state;
   logic              tx_full, armed, rxv_q;
   logic [MAX_WL-1:0] tx_hold, rx_q, rx_word;
   logic [WLW-1:0]    eff_wl;
   logic [5:0]        periods;
   logic [DCW-1:0]    dly_load_val;
   logic              run_ok, start, use_wait, enter_shift, tx_accept;
   logic              dly_expired, sclk_lvl, sample_now, period_end, last_bit, rx_strobe;

   always_comb begin
      if (cfg_wlen < WLW'(MIN_WL))      eff_wl = WLW'(MIN_WL);
      else if (cfg_wlen > WLW'(MAX_WL)) eff_wl = WLW'(MAX_WL);
      else                              eff_wl = cfg_wlen;
   end

   assign run_ok       = cfg_en && !cfg_slave;
   assign tx_busy      = tx_full || (state != ST_IDLE);
   assign tx_accept    = tx_wr && !tx_busy;
   assign start        = (state == ST_IDLE) && tx_full && run_ok;
   assign periods      = armed ? code_to_periods(cfg_dly_code) : 6'd0;
   assign use_wait     = (periods != 6'd0);
   assign dly_load_val = DCW'(int'(periods) * SYS_DIV - 1);
   assign enter_shift  = (start && !use_wait) ||
                         ((state == ST_WAIT) && dly_expired && run_ok);
   assign rx_strobe    = (state == ST_SHIFT) && sample_now && last_bit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
      end else if (!run_ok) begin
         state <= ST_IDLE;
      end else begin
         case (state)
            ST_IDLE:  if (tx_full) state <= use_wait ? ST_WAIT : ST_SHIFT;
            ST_WAIT:  if (dly_expired) state <= ST_SHIFT;
            ST_SHIFT: if (period_end && last_bit) state <= ST_IDLE;
            default:  state <= ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_full <= 1'b0;
         tx_hold <= '0;
         armed   <= 1'b1;
         rxv_q   <= 1'b0;
         rx_q    <= '0;
      end else begin
         if (tx_accept) begin
            tx_full <= 1'b1;
            tx_hold <= tx_data;
         end else if (start) begin
            tx_full <= 1'b0;
         end
         if (!cfg_en)    armed <= 1'b1;
         else if (start) armed <= 1'b0;
         if (tx_accept) begin
            rxv_q <= 1'b0;
         end else if (rx_strobe) begin
            rxv_q <= 1'b1;
            rx_q  <= rx_word;
         end
      end
   end

   spi_start_delay #(.CW(DCW)) u_delay (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (start && use_wait),
      .clear    (!run_ok),
      .load_val (dly_load_val),
      .expired  (dly_expired)
   );

   spi_phase_gen #(.DIV(SYS_DIV)) u_phase (
      .clk        (clk),
      .rst_n      (rst_n),
      .run        (state == ST_SHIFT),
      .sclk_lvl   (sclk_lvl),
      .sample_now (sample_now),
      .period_end (period_end)
   );

   spi_shift_core #(.MAX_WL(MAX_WL), .WLW(WLW)) u_shift (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (enter_shift),
      .wl         (eff_wl),
      .tx_word    (tx_hold),
      .sample_now (sample_now),
      .period_end (period_end),
      .miso       (miso),
      .mosi       (mosi),
      .last_bit   (last_bit),
      .rx_word    (rx_word)
   );

   assign sclk     = sclk_lvl;
   assign cs_n     = !((state == ST_SHIFT) && !cfg_three_pin);
   assign rx_data  = rx_q;
   assign rx_valid = rxv_q;

   AST_CLK_ONLY_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      sclk |-> (state == ST_SHIFT)); // R3
   AST_SLAVE_KEEPS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_slave |=> (state == ST_IDLE)); // R6
   AST_BUSY_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_wr && tx_busy) |=> (tx_hold == $past(tx_hold))); // R10
   AST_VALID_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_strobe && run_ok) |=> (sclk && rx_valid)); // R9
   AST_UNARMED_NO_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !armed) |=> (state == ST_SHIFT)); // R4

endmodule

// File: tb/tb_spi_delay_master.sv
module tb_spi_delay_master;
   localparam int DIV  = 4;
   localparam int HALF = DIV / 2;

   typedef struct packed {
      logic [2:0]  code;
      logic [4:0]  wl;
      logic [15:0] data;
      logic        three;
      logic [5:0]  exp_periods;
      logic [4:0]  exp_wl;
   } vec_t;

   localparam vec_t VECS [8] = '{
      '{3'd0, 5'd8,  16'h00A5, 1'b0, 6'd0,  5'd8},
      '{3'd1, 5'd16, 16'hBEEF, 1'b0, 6'd4,  5'd16},
      '{3'd2, 5'd4,  16'h0009, 1'b1, 6'd8,  5'd4},
      '{3'd3, 5'd12, 16'h05C3, 1'b0, 6'd16, 5'd12},
      '{3'd4, 5'd7,  16'h0055, 1'b0, 6'd32, 5'd7},
      '{3'd5, 5'd10, 16'h02AB, 1'b0, 6'd0,  5'd10},
      '{3'd7, 5'd20, 16'h8001, 1'b1, 6'd0,  5'd16},
      '{3'd6, 5'd3,  16'h000B, 1'b0, 6'd0,  5'd4}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_en = 1'b0, cfg_slave = 1'b0, cfg_three_pin = 1'b0;
   logic [2:0]  cfg_dly_code = '0;
   logic [4:0]  cfg_wlen = 5'd8;
   logic [15:0] tx_data = '0;
   logic tx_wr = 1'b0;
   logic tx_busy, rx_valid, sclk, mosi, miso, cs_n;
   logic [15:0] rx_data;
   int checks = 0;
   int fails = 0;

   always #5 clk = ~clk;
   assign miso = mosi;   // loopback

   spi_delay_master dut (
      .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_slave(cfg_slave),
      .cfg_three_pin(cfg_three_pin), .cfg_dly_code(cfg_dly_code), .cfg_wlen(cfg_wlen),
      .tx_data(tx_data), .tx_wr(tx_wr), .tx_busy(tx_busy), .rx_data(rx_data),
      .rx_valid(rx_valid), .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n)
   );

   task automatic check(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic logic [15:0] lowmask(input int w);
      return 16'((32'd1 << w) - 1);
   endfunction

   // Edge 0 is the edge right before the first negedge waited here.
   task automatic measure(input int base, input int dcyc, input int w,
                          input logic [15:0] data, input bit three, input string tag);
      int k_cs = -1, k_rise = -1, k_val = -1, k_busy = -1, nb = 0, bad = 0;
      logic prev = 1'b0;
      logic [15:0] got = '0;
      @(negedge clk);
      tx_wr = 1'b0;
      for (int k = 0; k < 3000; k++) begin
         if (!cs_n && k_cs < 0) k_cs = k;
         if (sclk && !prev) begin
            if (k_rise < 0) k_rise = k;
            got = {got[14:0], mosi};
            nb++;
         end
         if (sclk && cs_n && !three) bad = 1;
         if (!cs_n && three) bad = 1;
         if (rx_valid && k_val < 0) k_val = k;
         prev = sclk;
         if (!tx_busy) begin
            k_busy = k;
            break;
         end
         @(negedge clk);
      end
      if (three) check({tag, " R7"}, "cs_n low cycle", k_cs, -1);
      else       check({tag, " R3"}, "cs_n low cycle", k_cs, base + dcyc);
      check({tag, " R2"}, "first sclk rise", k_rise, base + dcyc + HALF);
      check({tag, three ? " R7" : " R3"}, "frame violations", bad, 0);
      check({tag, " R9"}, "rx_valid cycle", k_val, base + dcyc + (w - 1) * DIV + HALF);
      check({tag, " R10"}, "busy end cycle", k_busy, base + dcyc + w * DIV);
      check({tag, " R8"}, "bit count", nb, w);
      check({tag, " R8"}, "mosi word", int'(got & lowmask(w)), int'(data & lowmask(w)));
      check({tag, " R8"}, "rx_data", int'(rx_data), int'(data & lowmask(w)));
   endtask

   task automatic configure(input logic [2:0] code, input logic [4:0] wl, input bit three);
      cfg_en = 1'b0;
      @(negedge clk);
      cfg_dly_code = code;
      cfg_wlen = wl;
      cfg_three_pin = three;
      cfg_en = 1'b1;
      @(negedge clk);
   endtask

   task automatic write_word(input logic [15:0] d);
      tx_data = d;
      tx_wr = 1'b1;
   endtask

   initial begin
      #2_000_000;
      fails++;
      $display("FAIL R10 watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      int bad;
      // R1 reset state
      repeat (3) @(negedge clk);
      check("R1", "cs_n in reset", int'(cs_n), 1);
      check("R1", "sclk in reset", int'(sclk), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", "tx_busy", int'(tx_busy), 0);
      check("R1", "rx_valid", int'(rx_valid), 0);
      check("R1", "mosi", int'(mosi), 0);
      check("R1", "rx_data", int'(rx_data), 0);

      // Table walk: first word uses the wait, the second word has none (R4)
      foreach (VECS[i]) begin
         configure(VECS[i].code, VECS[i].wl, VECS[i].three);
         write_word(VECS[i].data);
         measure(1, int'(VECS[i].exp_periods) * DIV, int'(VECS[i].exp_wl),
                 VECS[i].data, VECS[i].three, $sformatf("vec%0d", i));
         write_word(~VECS[i].data);
         measure(1, 0, int'(VECS[i].exp_wl), ~VECS[i].data, VECS[i].three,
                 $sformatf("vec%0d R4 second word", i));
      end

      // R4: re-enable with the same code arms the wait again
      configure(3'd2, 5'd6, 1'b0);
      write_word(16'h002D);
      measure(1, 8 * DIV, 6, 16'h002D, 1'b0, "R4 rearm");

      // R5: word written while disabled waits for enable
      cfg_en = 1'b0;
      cfg_dly_code = 3'd1;
      cfg_wlen = 5'd8;
      cfg_three_pin = 1'b0;
      @(negedge clk);
      write_word(16'h003C);
      @(negedge clk);
      tx_wr = 1'b0;
      bad = 0;
      repeat (10) begin
         @(negedge clk);
         if (sclk || !cs_n || !tx_busy) bad++;
      end
      check("R5", "held while disabled", bad, 0);
      cfg_en = 1'b1;
      measure(0, 4 * DIV, 8, 16'h003C, 1'b0, "R5 enable");

      // R6: slave selected keeps the engine idle
      cfg_en = 1'b0;
      cfg_slave = 1'b1;
      cfg_dly_code = 3'd0;
      @(negedge clk);
      cfg_en = 1'b1;
      write_word(16'h005A);
      @(negedge clk);
      tx_wr = 1'b0;
      bad = 0;
      repeat (40) begin
         @(negedge clk);
         if (sclk || !cs_n || !tx_busy) bad++;
      end
      check("R6", "idle while slave", bad, 0);
      cfg_slave = 1'b0;
      measure(0, 0, 8, 16'h005A, 1'b0, "R6 release");

      // R10: writes during the word, and in its last busy cycle, are dropped
      configure(3'd0, 5'd4, 1'b0);
      write_word(16'h000A);
      @(negedge clk);           // after edge 0
      tx_wr = 1'b0;
      for (int k = 1; k <= 16; k++) begin
         @(negedge clk);        // after edge k
         if (k == 5) write_word(16'h0005);
         if (k == 6) tx_wr = 1'b0;
         if (k == 16) begin
            check("R10", "busy in last cycle", int'(tx_busy), 1);
            write_word(16'h0003);
         end
      end
      @(negedge clk);           // after edge 17
      tx_wr = 1'b0;
      check("R10", "busy after last-cycle write", int'(tx_busy), 0);
      bad = 0;
      repeat (20) begin
         @(negedge clk);
         if (!cs_n || sclk || tx_busy) bad++;
      end
      check("R10", "no transfer from dropped write", bad, 0);
      check("R10", "rx_data keeps first word", int'(rx_data), 16'h000A);
      check("R9", "rx_valid kept after dropped write", int'(rx_valid), 1);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule